// File: doc/BRIEF.md
# Way-Predicting Four-Way Read Cache

This block is a set-associative read cache that saves array energy by guessing which way holds the requested line. Each lookup reads one tag and one data entry, from the way that the set's predictor names. If that tag is valid and equal to the request tag, the word is returned one cycle after the request is accepted. Only one tag array and one data array were switched on for it.

When the guess is wrong, the block spends a second cycle reading the other three ways together. A hit there returns the word one cycle later than a correct guess, and the set's predictor is moved to the way that hit. When no way matches, the block reports a miss. The requester then supplies the whole line through the refill port. Each set has a round-robin victim pointer that picks the way the refill overwrites, and the predictor is set to that way.

Per-way tag-enable and data-enable outputs show which arrays each cycle reads, so the energy saving can be measured at the ports. A refill is expected only after a miss for the same line, and not in a cycle that also carries a lookup of the same set.

Top module: `wpc_cache`

## Requirements
- R1: After reset every line is invalid and every set predicts way 0. The first lookup of any address therefore enables only way 0 and ends in a miss. All response flags are low and req_ready is high after reset.
- R2: A request accepted in the first-probe state (req_valid and req_ready both high) enables exactly one tag array and the same single data array, in the same cycle. That way is the one the set's predictor currently holds.
- R3: When the predicted way is valid and its tag matches, rsp_hit_fast is high for one cycle, one cycle after acceptance. rsp_data then carries the requested word.
- R4: When the predicted way does not match, req_ready is low in the next cycle. In that cycle the tag and data enables are set for the other three ways and clear for the predicted way, and no response flag is raised.
- R5: A match in the second cycle raises rsp_hit_slow for one cycle, two cycles after acceptance, with the requested word. The set's predictor then holds the way that hit.
- R6: When no way matches, rsp_miss is high for one cycle, two cycles after acceptance, and rsp_data is zero. rsp_data is also zero in every cycle without a hit flag.
- R7: A refill writes the way chosen by the set's round-robin pointer. The pointer then advances, so a set's refills use ways 0, 1, 2, 3 and then wrap to 0, which evicts the oldest line.
- R8: After a refill, the next lookup of that set predicts the way just written.
- R9: At most one of rsp_hit_fast, rsp_hit_slow and rsp_miss is high in any cycle.
- R10: In a cycle with no accepted request and no second probe, all tag and data enables are low.
- R11: The address splits into three fields. The word offset is bits [OFF_W-1:0] and selects word N of the line, which is fill_line[N*WORD_W +: WORD_W]. The set index is the next SET_W bits, and the remaining upper bits are the tag. Sets keep separate predictors and victim pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Word address of the lookup |
| req_ready | output | 1 | High when a new lookup can be accepted (low during the second probe) |
| rsp_hit_fast | output | 1 | Hit in the predicted way |
| rsp_hit_slow | output | 1 | Hit in one of the other ways, one cycle later |
| rsp_miss | output | 1 | No way holds the line |
| rsp_data | output | WORD_W | Returned word, zero unless a hit flag is high |
| fill_valid | input | 1 | Refill line present |
| fill_addr | input | ADDR_W | Address of the refilled line (offset ignored) |
| fill_line | input | WORD_W*2**OFF_W | Refill data, word 0 in the low bits |
| tag_en | output | WAYS | Per-way tag array read enables |
| data_en | output | WAYS | Per-way data array read enables |

## Verification
A wrong predictor entry does not corrupt data. It shows up on the enables in the very cycle of the next lookup of that set, and a hit then turns from fast to slow one cycle later than expected. A wrong victim pointer or a lost valid bit shows up as a hit or miss flag that differs from the reference model. This appears two cycles after the next lookup of that line. A wrong word select or a stale tag shows up in rsp_data in the cycle the hit flag is raised. The bench therefore compares every enable and flag in every cycle of every lookup against its behavioural model.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Lookup control: first probe of the predicted way, or the fallback probe.
    typedef enum logic [0:0] {
        ST_FIRST = 1'b0,
        ST_REST  = 1'b1
    } wpc_state_e;

    // Default geometry, used as the top module's parameter defaults.
    localparam int WPC_ADDR_W = 16;
    localparam int WPC_SET_W  = 4;
    localparam int WPC_OFF_W  = 2;
    localparam int WPC_WAYS   = 4;
    localparam int WPC_WORD_W = 32;

    // One-hot decode of a way index, up to 32 ways.
    function automatic logic [31:0] way_onehot(input int unsigned way);
        logic [31:0] v;
        v = '0;
        v[way[4:0]] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
    parameter int WAYS  = 4,
    parameter int SET_W = 4,
    parameter int TAG_W = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [$clog2(WAYS)-1:0]      wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [WAYS-1:0]              rd_en,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_valid
);
    localparam int SETS = 1 << SET_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]             valid_q;
        logic [TAG_W-1:0]            tag_q [SETS];
        logic                        wr_here;

        assign wr_here = wr_en && (int'(wr_way) == w);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
            end else if (wr_here) begin
                valid_q[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q[wr_set] <= wr_tag;
            end
        end

        // An array that is not enabled presents nothing to the compare.
        assign rd_valid[w] = rd_en[w] & valid_q[rd_set];
        assign rd_tag[w]   = rd_en[w] ? tag_q[rd_set] : '0;
    end

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
    parameter int WAYS   = 4,
    parameter int SET_W  = 4,
    parameter int LINE_W = 128
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [$clog2(WAYS)-1:0]      wr_way,
    input  logic [LINE_W-1:0]            wr_line,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [WAYS-1:0]              rd_en,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_line
);
    localparam int SETS = 1 << SET_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_way) == w)) begin
                line_q[wr_set] <= wr_line;
            end
        end

        assign rd_line[w] = rd_en[w] ? line_q[rd_set] : '0;
    end

endmodule

// File: rtl/wpc_way_pred.sv
module wpc_way_pred #(
    parameter int WAYS  = 4,
    parameter int SET_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             rd_set,
    output logic [$clog2(WAYS)-1:0]      rd_way,
    input  logic                         upd_en,
    input  logic [SET_W-1:0]             upd_set,
    input  logic [$clog2(WAYS)-1:0]      upd_way,
    input  logic                         fill_en,
    input  logic [SET_W-1:0]             fill_set,
    output logic [$clog2(WAYS)-1:0]      fill_way
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] pred_q [SETS];
    logic [WAY_W-1:0] vict_q [SETS];

    assign rd_way   = pred_q[rd_set];
    assign fill_way = vict_q[fill_set];

    // A refill takes precedence over a fallback-hit update of the same set.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                pred_q[s] <= '0;
                vict_q[s] <= '0;
            end
        end else begin
            if (upd_en && !(fill_en && fill_set == upd_set)) begin
                pred_q[upd_set] <= upd_way;
            end
            if (fill_en) begin
                pred_q[fill_set] <= vict_q[fill_set];
                vict_q[fill_set] <= (int'(vict_q[fill_set]) == WAYS - 1)
                                    ? '0 : vict_q[fill_set] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = WPC_ADDR_W,
    parameter int SET_W  = WPC_SET_W,
    parameter int OFF_W  = WPC_OFF_W,
    parameter int WAYS   = WPC_WAYS,
    parameter int WORD_W = WPC_WORD_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    output logic                              req_ready,
    output logic                              rsp_hit_fast,
    output logic                              rsp_hit_slow,
    output logic                              rsp_miss,
    output logic [WORD_W-1:0]                 rsp_data,
    input  logic                              fill_valid,
    input  logic [ADDR_W-1:0]                 fill_addr,
    input  logic [WORD_W*(2**OFF_W)-1:0]      fill_line,
    output logic [WAYS-1:0]                   tag_en,
    output logic [WAYS-1:0]                   data_en
);
    localparam int WPL    = 1 << OFF_W;
    localparam int LINE_W = WORD_W * WPL;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    wpc_state_e                  state_q;
    logic [ADDR_W-1:0]           addr_q;
    logic [WAY_W-1:0]            first_way_q;

    logic [ADDR_W-1:0]           look_addr;
    logic [TAG_W-1:0]            look_tag;
    logic [SET_W-1:0]            look_set;
    logic [OFF_W-1:0]            look_off;
    logic [WAY_W-1:0]            pred_way;
    logic [WAYS-1:0]             pred_mask;
    logic [WAYS-1:0]             rd_en;
    logic                        first_go;

    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic [WAYS-1:0]             match;
    logic                        any_hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WORD_W-1:0]           hit_word;

    logic [SET_W-1:0]            fill_set;
    logic [TAG_W-1:0]            fill_tag;
    logic [WAY_W-1:0]            fill_way;
    logic                        upd_en;

    // ---------------- lookup address and enables ----------------
    assign look_addr = (state_q == ST_REST) ? addr_q : req_addr;
    assign look_off  = look_addr[OFF_W-1:0];
    assign look_set  = look_addr[OFF_W +: SET_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];

    assign fill_set  = fill_addr[OFF_W +: SET_W];
    assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];

    assign req_ready = (state_q == ST_FIRST);
    assign first_go  = req_ready && req_valid;

    always_comb begin
        if (state_q == ST_REST) begin
            pred_mask = WAYS'(way_onehot(int'(first_way_q)));
            rd_en     = ~pred_mask;
        end else begin
            pred_mask = WAYS'(way_onehot(int'(pred_way)));
            rd_en     = first_go ? pred_mask : '0;
        end
    end

    assign tag_en  = rd_en;
    assign data_en = rd_en;

    // ---------------- storage ----------------
    wpc_way_pred #(
        .WAYS  (WAYS),
        .SET_W (SET_W)
    ) u_pred (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (look_set),
        .rd_way   (pred_way),
        .upd_en   (upd_en),
        .upd_set  (look_set),
        .upd_way  (hit_way),
        .fill_en  (fill_valid),
        .fill_set (fill_set),
        .fill_way (fill_way)
    );

    wpc_tag_store #(
        .WAYS  (WAYS),
        .SET_W (SET_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fill_valid),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_tag   (fill_tag),
        .rd_set   (look_set),
        .rd_en    (rd_en),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid)
    );

    wpc_data_store #(
        .WAYS   (WAYS),
        .SET_W  (SET_W),
        .LINE_W (LINE_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_line (fill_line),
        .rd_set  (look_set),
        .rd_en   (rd_en),
        .rd_line (rd_line)
    );

    // ---------------- compare and select ----------------
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = rd_valid[w] && (rd_tag[w] == look_tag);
    end

    always_comb begin
        any_hit = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                any_hit = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit_word = rd_line[hit_way][look_off*WORD_W +: WORD_W];
    assign upd_en   = (state_q == ST_REST) && any_hit;

    // ---------------- control and response registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_FIRST;
            addr_q       <= '0;
            first_way_q  <= '0;
            rsp_hit_fast <= 1'b0;
            rsp_hit_slow <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_data     <= '0;
        end else begin
            rsp_hit_fast <= 1'b0;
            rsp_hit_slow <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_data     <= '0;
            unique case (state_q)
                ST_FIRST: begin
                    if (first_go) begin
                        if (any_hit) begin
                            rsp_hit_fast <= 1'b1;
                            rsp_data     <= hit_word;
                        end else begin
                            state_q     <= ST_REST;
                            addr_q      <= req_addr;
                            first_way_q <= pred_way;
                        end
                    end
                end
                ST_REST: begin
                    state_q <= ST_FIRST;
                    if (any_hit) begin
                        rsp_hit_slow <= 1'b1;
                        rsp_data     <= hit_word;
                    end else begin
                        rsp_miss     <= 1'b1;
                    end
                end
                default: state_q <= ST_FIRST;
            endcase
        end
    end

endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk #(
    parameter int WAYS   = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_hit_fast,
    input logic              rsp_hit_slow,
    input logic              rsp_miss,
    input logic [WORD_W-1:0] rsp_data,
    input logic [WAYS-1:0]   tag_en,
    input logic [WAYS-1:0]   data_en
);

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit_fast, rsp_hit_slow, rsp_miss}));

    assert_single_way_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ($countones(tag_en) == 1 && data_en == tag_en));

    assert_first_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_hit_fast != !req_ready));

    assert_fallback_ways_R4: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> ($countones(tag_en) == WAYS - 1 && data_en == tag_en
                        && !rsp_hit_fast && !rsp_hit_slow && !rsp_miss));

    assert_second_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> ((rsp_hit_slow || rsp_miss) && req_ready));

    assert_miss_no_data_R6: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit_fast || rsp_hit_slow) |-> rsp_data == '0);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |-> (tag_en == '0 && data_en == '0));

endmodule

bind wpc_cache wpc_cache_chk #(
    .WAYS   (WAYS),
    .WORD_W (WORD_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_hit_fast (rsp_hit_fast),
    .rsp_hit_slow (rsp_hit_slow),
    .rsp_miss     (rsp_miss),
    .rsp_data     (rsp_data),
    .tag_en       (tag_en),
    .data_en      (data_en)
);

// File: tb/wpc_cache_tb.sv
`timescale 1ns/1ps
module wpc_cache_tb;
    localparam int ADDR_W = 16;
    localparam int SET_W  = 4;
    localparam int OFF_W  = 2;
    localparam int WAYS   = 4;
    localparam int WORD_W = 32;
    localparam int WPL    = 1 << OFF_W;
    localparam int LINE_W = WORD_W * WPL;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int SETS   = 1 << SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_hit_fast, rsp_hit_slow, rsp_miss;
    logic [WORD_W-1:0] rsp_data;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [LINE_W-1:0] fill_line = '0;
    logic [WAYS-1:0]   tag_en, data_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural model
    bit        m_val  [SETS][WAYS];
    int        m_tag  [SETS][WAYS];
    int        m_gen  [SETS][WAYS];
    int        m_pred [SETS];
    int        m_vict [SETS];
    int        gen_ctr = 0;

    always #2 clk = ~clk;

    wpc_cache #(
        .ADDR_W (ADDR_W), .SET_W (SET_W), .OFF_W (OFF_W),
        .WAYS (WAYS), .WORD_W (WORD_W)
    ) u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .rsp_hit_fast (rsp_hit_fast), .rsp_hit_slow (rsp_hit_slow),
        .rsp_miss (rsp_miss), .rsp_data (rsp_data),
        .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_line (fill_line),
        .tag_en (tag_en), .data_en (data_en)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkw(int tg, int st, int w, int g);
        return WORD_W'(32'h5A00_0000 ^ (g << 16) ^ (tg << 6) ^ (st << 2) ^ w);
    endfunction

    function automatic logic [ADDR_W-1:0] mka(int tg, int st, int off);
        return {TAG_W'(tg), SET_W'(st), OFF_W'(off)};
    endfunction

    task automatic do_fill(input int tg, input int st);
        int w;
        int g;
        g = ++gen_ctr;
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mka(tg, st, 0);
        for (int k = 0; k < WPL; k++) fill_line[k*WORD_W +: WORD_W] = mkw(tg, st, k, g);
        @(negedge clk);
        fill_valid = 1'b0;
        w = m_vict[st];
        m_val[st][w] = 1'b1;
        m_tag[st][w] = tg;
        m_gen[st][w] = g;
        m_pred[st]   = w;
        m_vict[st]   = (w + 1) % WAYS;
    endtask

    // Runs one lookup and checks every cycle of it; hit reports the outcome.
    task automatic do_look(input int tg, input int st, input int off, output bit hit);
        int p;
        int hw;
        @(negedge clk);
        chk("R10 idle tag_en", 64'(tag_en), 64'(0));
        chk("R10 idle ready", 64'(req_ready), 64'(1));
        req_valid = 1'b1;
        req_addr  = mka(tg, st, off);
        #1;
        p = m_pred[st];
        chk("R2 R8 first tag_en", 64'(tag_en), 64'(1 << p));
        chk("R2 first data_en", 64'(data_en), 64'(1 << p));
        hw = -1;
        for (int w = 0; w < WAYS; w++) if (m_val[st][w] && m_tag[st][w] == tg) hw = w;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (hw == p) begin
            chk("R3 fast flag", 64'({rsp_hit_fast, rsp_hit_slow, rsp_miss}), 64'(3'b100));
            chk("R3 R11 fast data", 64'(rsp_data), 64'(mkw(tg, st, off, m_gen[st][hw])));
            chk("R3 ready", 64'(req_ready), 64'(1));
        end else begin
            chk("R4 ready low", 64'(req_ready), 64'(0));
            chk("R4 rest tag_en", 64'(tag_en), 64'(4'hF ^ (1 << p)));
            chk("R4 rest data_en", 64'(data_en), 64'(4'hF ^ (1 << p)));
            chk("R4 no flag", 64'({rsp_hit_fast, rsp_hit_slow, rsp_miss}), 64'(0));
            @(negedge clk);
            #1;
            if (hw >= 0) begin
                chk("R5 slow flag", 64'({rsp_hit_fast, rsp_hit_slow, rsp_miss}), 64'(3'b010));
                chk("R5 R11 slow data", 64'(rsp_data), 64'(mkw(tg, st, off, m_gen[st][hw])));
                m_pred[st] = hw;
            end else begin
                chk("R6 miss flag", 64'({rsp_hit_fast, rsp_hit_slow, rsp_miss}), 64'(3'b001));
                chk("R6 miss data", 64'(rsp_data), 64'(0));
            end
        end
        hit = (hw >= 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit h;
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 0;
            m_vict[s] = 0;
            for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset flags", 64'({rsp_hit_fast, rsp_hit_slow, rsp_miss}), 64'(0));
        chk("R1 reset ready", 64'(req_ready), 64'(1));
        chk("R1 reset data", 64'(rsp_data), 64'(0));

        // R1: cold miss, then refill and fast hit
        do_look(5, 1, 0, h);
        chk("R1 cold miss", 64'(h), 64'(0));
        do_fill(5, 1);
        do_look(5, 1, 2, h);
        // R8: second line goes to way 1, prediction moves there
        do_fill(9, 1);
        do_look(5, 1, 1, h);          // R5 slow hit in way 0
        do_look(5, 1, 3, h);          // fast again
        do_look(9, 1, 0, h);          // slow hit way 1
        // R7: fill ways 2,3 then wrap to way 0
        do_fill(11, 1);
        do_fill(12, 1);
        do_fill(13, 1);
        do_look(5, 1, 0, h);
        chk("R7 evicted line misses", 64'(h), 64'(0));
        do_look(13, 1, 1, h);
        chk("R7 wrapped line hits", 64'(h), 64'(1));
        do_look(9, 1, 2, h);
        chk("R7 way1 kept", 64'(h), 64'(1));
        // R11: other sets are independent
        do_look(5, 2, 0, h);
        chk("R11 other set miss", 64'(h), 64'(0));
        do_fill(5, 2);
        for (int o = 0; o < WPL; o++) do_look(5, 2, o, h);

        // Mixed traffic with evictions over two sets
        for (int i = 0; i < 80; i++) begin
            int tg;
            int st;
            tg = (i * 7 + i / 5) % 6;
            st = 3 + (i * 3) % 2;
            do_look(tg, st, i % WPL, h);
            if (!h) do_fill(tg, st);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule